// File: doc/BRIEF.md
# Two-Speed Successive-Approximation Conversion Controller

This block sequences a 12-bit successive-approximation conversion around an external DAC and an external single-bit comparator. A rising edge on the start input launches a conversion. The controller then performs one trial per bit, beginning with the most significant. In each trial it raises the bit under test in the DAC code and waits a settling dwell. At the end of that dwell it samples the comparator and either keeps or clears the bit.

The dwell is not uniform. The three highest-order trials make the largest DAC steps and get a long dwell. All later trials use a short dwell. This shortens the total conversion compared with running every trial at the slow rate.

Each decided bit is presented on a serial output with a one-cycle strobe. The complete code is loaded into a parallel result register when the least significant bit is decided. At that same edge the conversion-complete flag is raised. From then on the comparator input is ignored until the next start edge, so noise cannot disturb the finished result.

Top module: `sar2_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, dac_o, result_o, done_o, ser_data_o and ser_strobe_o are all zero until a conversion is started.
- R2: A conversion is accepted on a clock edge where start_i is sampled high and was sampled low at the previous edge, provided no conversion is in progress. done_o falls at that same edge, and dac_o becomes 12'h800.
- R3: Each trial sets the bit under test to 1 in dac_o and keeps all bits already decided. At the end of the dwell, cmp_i = 1 keeps the bit and cmp_i = 0 clears it. Bits are decided from bit 11 down to bit 0. With a comparator reporting dac_o <= input, the result equals the input.
- R4: Trials for bits 11, 10 and 9 each last SLOW_DWELL clock cycles. Trials for bits 8 to 0 each last FAST_DWELL cycles. The final decision falls 3*SLOW_DWELL + 9*FAST_DWELL edges after the accepting edge.
- R5: done_o rises only at the edge that decides bit 0, together with that bit's strobe. While done_o is high, result_o equals dac_o.
- R6: A start_i rising edge that arrives during a conversion is ignored. The running conversion keeps its timing and its result.
- R7: After completion, changes on cmp_i have no effect. dac_o, result_o and ser_data_o hold, and no strobe occurs, until the next accepted start.
- R8: At each decision, ser_data_o takes the decided bit and ser_strobe_o is high for exactly one cycle. A conversion gives 12 strobes, MSB first.
- R9: result_o changes only at completion and keeps the previous result throughout a following conversion.
- R10: start_i held high after a conversion does not start another one; only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert command, acted on at its rising edge |
| cmp_i | input | 1 | Comparator output: 1 when the DAC level does not exceed the input |
| dac_o | output | 12 | Trial code driven to the DAC |
| result_o | output | 12 | Parallel result of the last completed conversion |
| done_o | output | 1 | Conversion complete |
| ser_data_o | output | 1 | Most recently decided bit |
| ser_strobe_o | output | 1 | One-cycle pulse marking each decided bit |

## Verification
The checker module watches the following on every cycle:
- done_o rises only together with a bit strobe.
- The result register changes only when done_o rises.
- result_o equals dac_o while done_o is high.
- dac_o is frozen during the complete state.
- Strobes are single-cycle pulses.

The bench scenarios cover what depends on an analog input value and on elapsed time:
- correct binary-search results across a range of input codes;
- the exact slow-then-fast spacing of strobes;
- the serial bit order;
- immunity to a start retrigger during a conversion;
- immunity to comparator changes after completion;
- the edge-only nature of the start input.

// File: rtl/sar2_pkg.sv
package sar2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sar2_state_e;
endpackage

// File: rtl/sar2_edge.sv
module sar2_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sar2_dwell.sv
module sar2_dwell #(
  parameter int SLOW_DWELL = 8,
  parameter int FAST_DWELL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic slow_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (SLOW_DWELL > 1) ? $clog2(SLOW_DWELL) : 1;
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_DWELL - 1);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_DWELL - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= slow_i ? SLOW_LD : FAST_LD;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sar2_seq.sv
module sar2_seq
  import sar2_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int SLOW_BITS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             expire_i,
  input  logic             cmp_i,
  output logic             load_o,
  output logic             slow_o,
  output logic             run_o,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             ser_data_o,
  output logic             ser_strobe_o
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIDTH - 1);
  localparam logic [IDX_W:0]   TRIALS  = (IDX_W+1)'(WIDTH);
  localparam logic [IDX_W:0]   SLOW_N  = (IDX_W+1)'(SLOW_BITS);
  localparam logic [WIDTH-1:0] MSB_SET = {1'b1, {(WIDTH-1){1'b0}}};

  sar2_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] code_q, result_q, next_code;
  logic             done_q, ser_d_q, ser_s_q;
  logic             accept, decide, last;
  logic [IDX_W-1:0] idx_m1;
  logic [IDX_W:0]   trial_next;

  assign accept     = rise_i && (state_q != ST_RUN);
  assign decide     = (state_q == ST_RUN) && expire_i;
  assign last       = (idx_q == '0);
  assign idx_m1     = idx_q - 1'b1;
  assign trial_next = TRIALS - {1'b0, idx_q};

  always_comb begin
    next_code         = code_q;
    next_code[idx_q]  = cmp_i;
    if (!last) next_code[idx_m1] = 1'b1;
  end

  // timer reload: at start, and after each non-final decision
  assign load_o = accept || (decide && !last);
  assign slow_o = accept || (trial_next < SLOW_N);
  assign run_o  = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      code_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      ser_d_q  <= 1'b0;
      ser_s_q  <= 1'b0;
    end else begin
      ser_s_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        idx_q   <= IDX_TOP;
        code_q  <= MSB_SET;
        done_q  <= 1'b0;
      end else if (decide) begin
        code_q  <= next_code;
        ser_d_q <= cmp_i;
        ser_s_q <= 1'b1;
        if (last) begin
          state_q  <= ST_DONE;
          done_q   <= 1'b1;
          result_q <= next_code;
        end else begin
          idx_q <= idx_m1;
        end
      end
    end
  end

  assign code_o       = code_q;
  assign result_o     = result_q;
  assign done_o       = done_q;
  assign ser_data_o   = ser_d_q;
  assign ser_strobe_o = ser_s_q;
endmodule

// File: rtl/sar2_ctrl.sv
module sar2_ctrl #(
  parameter int WIDTH      = 12,
  parameter int SLOW_BITS  = 3,
  parameter int SLOW_DWELL = 8,
  parameter int FAST_DWELL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             ser_data_o,
  output logic             ser_strobe_o
);
  initial begin
    if (SLOW_DWELL <= FAST_DWELL) $error("SLOW_DWELL must exceed FAST_DWELL");
    if (FAST_DWELL < 2)           $error("FAST_DWELL must be at least 2");
    if (SLOW_BITS < 1 || SLOW_BITS > WIDTH) $error("SLOW_BITS out of range");
  end

  logic rise, load, slow, run, expire;

  sar2_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (start_i),
    .rise_o (rise)
  );

  sar2_dwell #(
    .SLOW_DWELL (SLOW_DWELL),
    .FAST_DWELL (FAST_DWELL)
  ) u_dwell (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .slow_i   (slow),
    .run_i    (run),
    .expire_o (expire)
  );

  sar2_seq #(
    .WIDTH     (WIDTH),
    .SLOW_BITS (SLOW_BITS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .expire_i     (expire),
    .cmp_i        (cmp_i),
    .load_o       (load),
    .slow_o       (slow),
    .run_o        (run),
    .code_o       (dac_o),
    .result_o     (result_o),
    .done_o       (done_o),
    .ser_data_o   (ser_data_o),
    .ser_strobe_o (ser_strobe_o)
  );
endmodule

// File: rtl/sar2_ctrl_chk.sv
module sar2_ctrl_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] dac_o,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o,
  input logic             ser_strobe_o
);
  assert_done_with_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ser_strobe_o);

  assert_result_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == dac_o));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |-> $stable(result_o));

  assert_done_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(dac_o));

  assert_strobe_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_strobe_o |=> !ser_strobe_o);

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> !ser_strobe_o);
endmodule

bind sar2_ctrl sar2_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dac_o        (dac_o),
  .result_o     (result_o),
  .done_o       (done_o),
  .ser_strobe_o (ser_strobe_o)
);

// File: tb/sar2_ctrl_test.sv
module sar2_ctrl_test;
  localparam int W  = 12;
  localparam int S  = 8;
  localparam int F  = 3;
  localparam int NV = 8;
  // {input level, expected result}
  localparam logic [2*W-1:0] VEC [NV] = '{
    {12'd0,    12'd0},
    {12'd4095, 12'd4095},
    {12'd2048, 12'd2048},
    {12'd2047, 12'd2047},
    {12'd1,    12'd1},
    {12'hAAA,  12'hAAA},
    {12'h555,  12'h555},
    {12'd1234, 12'd1234}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp;
  logic [W-1:0] dac, result;
  logic         done, sdat, sstb;
  int           checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  assign cmp = (dac <= vin);

  sar2_ctrl #(.WIDTH(W), .SLOW_BITS(3), .SLOW_DWELL(S), .FAST_DWELL(F)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .cmp_i(cmp),
    .dac_o(dac), .result_o(result), .done_o(done),
    .ser_data_o(sdat), .ser_strobe_o(sstb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // One conversion; retrig pulses start mid-run, hold keeps start high afterwards.
  task automatic convert(input logic [W-1:0] v, input logic [W-1:0] exp,
                         input bit retrig, input bit hold);
    int n = 0, ns = 0;
    int t [W];
    logic [W-1:0] sbits = '0;
    logic [W-1:0] prev_res;
    bit done_seen = 0;
    @(negedge clk);
    prev_res = result;
    vin = v;
    start = 1'b1;
    while (!done_seen && n < 500) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk("R2 done low after start", done, 0);
        chk("R2 dac msb trial", dac, 12'h800);
        if (!hold) start = 1'b0;
      end
      if (retrig && n == 10) start = 1'b1;
      if (retrig && n == 12) start = 1'b0;
      if (n == 5) chk("R9 result held during run", result, prev_res);
      if (sstb) begin
        if (ns < W) t[ns] = n;
        sbits = {sbits[W-2:0], sdat};
        ns++;
      end
      if (done) done_seen = 1;
    end
    chk("R3 result", result, exp);
    chk("R8 serial bits msb first", sbits, exp);
    chk("R8 strobe count", ns, W);
    chk("R4 total time", n, 3*S + 9*F + 1);
    if (ns == W) begin
      chk("R4 first slow trial", t[0], S + 1);
      chk("R4 slow gap", t[2] - t[1], S);
      chk("R4 fast gap", t[3] - t[2], F);
      chk("R4 fast gap tail", t[11] - t[10], F);
      chk("R5 done with lsb strobe", t[11], n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset dac", dac, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset result", result, 0);
    chk("R1 reset strobe", sstb, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle dac", dac, 0);
    chk("R1 idle done", done, 0);

    for (int i = 0; i < NV; i++) begin
      convert(VEC[i][2*W-1:W], VEC[i][W-1:0], 0, 0);
      repeat (2) @(negedge clk);
    end

    // R6: retrigger during conversion
    convert(12'd3000, 12'd3000, 1, 0);

    // R7: comparator changes after completion are ignored
    begin
      logic [W-1:0] d0, r0;
      logic s0;
      int stb = 0;
      d0 = dac; r0 = result; s0 = sdat;
      vin = ~vin;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sstb) stb++;
      end
      chk("R7 dac frozen", dac, d0);
      chk("R7 result frozen", result, r0);
      chk("R7 serial frozen", sdat, s0);
      chk("R7 no strobe", stb, 0);
      chk("R7 done held", done, 1);
    end

    // R10: start held high after completion does not retrigger
    convert(12'd77, 12'd77, 0, 1);
    begin
      int stb = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (sstb) stb++;
      end
      chk("R10 no second conversion", stb, 0);
      chk("R10 done stays", done, 1);
      chk("R10 result kept", result, 12'd77);
    end
    start = 1'b0;
    @(negedge clk);
    convert(12'd3900, 12'd3900, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule